// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the register and command engine that a host processor sees in a PC-style keyboard controller. The host reaches it through two byte-wide ports, a data port and a command/status port, selected by one address line. Behind them sit a status register, a command byte, an output register holding bytes for the host, and an output port the host cannot address directly. The output port drives the system reset line and the A20 address gate.

A byte written to the command port is decoded as a controller command. Some commands answer at once by loading the output register. Others change the command byte or start a timed low pulse on output-port lines. Others arm a redirection, so that the next data-port write goes to the command byte, the output port, the output register or the auxiliary device. Without a redirection, a data-port write is forwarded to the keyboard. Bytes coming from an attached device arrive on a valid/ready handshake and land in the output register. Outgoing bytes leave on a valid/ready handshake of their own. The serial line protocol is handled outside this block.

Top module: `kbc_host_regs`

## Requirements
- R1: After reset, the output register and input register are empty, the command byte is 00h, the output port reads E1h (bits 7:6 and bit 0 high, bit 5 set because the input register is empty) and the interrupt request is low.
- R2: A status read (host_sel=1) returns, from bit 0 upward: output-full, input-full, system flag, last-write-was-command, keyboard-unlocked switch, transmit timeout, receive timeout, and even parity of the last device byte. Read data appears on host_rdata the cycle after the read strobe.
- R3: A command-port write sets status bit 3 and status bit 1; a data-port write clears bit 3 and sets bit 1; bit 1 clears once the byte has been consumed. Writes made while bit 1 is set are dropped.
- R4: A data byte with no armed redirection is offered to the keyboard on kbd_tx_valid/tx_data, held stable until tx_ready, with status bit 1 kept set until the handshake completes.
- R5: Command 60h loads the next data byte into the command byte; command 20h returns the command byte; command-byte bit 2 appears as status bit 2.
- R6: Command D1h loads the next data byte into the output port; D0h returns the output port. Output-port bit 4 shows output-full and bit 5 shows input-empty; bit 0 is the reset line and bit 1 the A20 gate.
- R7: After D2h or D3h the next data byte enters the output register as if a device had sent it; after D4h it is offered on aux_tx_valid, never on kbd_tx_valid at the same time.
- R8: Command AAh returns 55h; command E0h returns the keyboard clock line in bit 0 and the keyboard data line in bit 1.
- R9: Commands ADh/AEh set/clear command-byte bit 4; A7h/A8h set/clear bit 5.
- R10: irq is high exactly when the output register is full and command-byte bit 0 is set, and drops on the cycle a data-port read empties the register.
- R11: A device byte is taken only while dev_rx_ready is high (output and input registers both empty); while it is held off the output register keeps its contents. Its parity flag is stored in status bit 7.
- R12: A command F0h–FFh drives low, for PULSE_CYC cycles, each of output-port bits 0–3 whose command bit is 0, leaving the others unchanged.
- R13: A data-port read clears output-full; the timeout flags are sticky and clear on a data-port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 = data port, 1 = command/status port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| irq | output | 1 | Output-full interrupt request |
| dev_rx_valid | input | 1 | Device byte offered |
| dev_rx_data | input | 8 | Device byte |
| dev_rx_even | input | 1 | Device byte arrived with even parity |
| dev_rx_ready | output | 1 | Block can take a device byte |
| kbd_tx_valid | output | 1 | Byte offered to the keyboard |
| aux_tx_valid | output | 1 | Byte offered to the auxiliary device |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Serial side accepts the outgoing byte |
| tx_timeout | input | 1 | Pulse: transmit timed out |
| rx_timeout | input | 1 | Pulse: receive timed out |
| kbd_unlocked | input | 1 | Keyboard lock switch, 1 = enabled |
| kclk_in | input | 1 | Keyboard clock line state |
| kdat_in | input | 1 | Keyboard data line state |
| out_port | output | 8 | Output port lines, bit 0 reset, bit 1 A20 |

## Verification
The assertions assume the host never writes while status bit 1 is set, never reads and writes in the same cycle, and that a device keeps dev_rx_valid and its byte steady until it sees dev_rx_ready. The stimulus tasks wait for each written byte to be consumed before the next write and drive the device side only through a send that holds until ready. The line inputs and the lock switch are changed only while no command that samples them is in flight.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  // redirection armed for the next data-port byte
  typedef enum logic [2:0] {
    PEND_NONE,
    PEND_CMDB,
    PEND_OPORT,
    PEND_OBUF,
    PEND_AUX
  } pend_e;

  // immediate response loaded into the output register
  typedef enum logic [2:0] {
    RSP_NONE,
    RSP_CMDB,
    RSP_OPORT,
    RSP_LINES,
    RSP_SELF
  } rsp_e;

  typedef struct packed {
    rsp_e       rsp;
    pend_e      pend;
    logic [7:0] cb_set;
    logic [7:0] cb_clr;
    logic       pulse;
    logic [3:0] pulse_mask;
  } act_t;

  localparam logic [7:0] OP_RD_CMDB  = 8'h20;
  localparam logic [7:0] OP_WR_CMDB  = 8'h60;
  localparam logic [7:0] OP_AUX_OFF  = 8'hA7;
  localparam logic [7:0] OP_AUX_ON   = 8'hA8;
  localparam logic [7:0] OP_SELFTEST = 8'hAA;
  localparam logic [7:0] OP_KBD_OFF  = 8'hAD;
  localparam logic [7:0] OP_KBD_ON   = 8'hAE;
  localparam logic [7:0] OP_RD_OPORT = 8'hD0;
  localparam logic [7:0] OP_WR_OPORT = 8'hD1;
  localparam logic [7:0] OP_FAKE_KBD = 8'hD2;
  localparam logic [7:0] OP_FAKE_AUX = 8'hD3;
  localparam logic [7:0] OP_TO_AUX   = 8'hD4;
  localparam logic [7:0] OP_RD_LINES = 8'hE0;

  localparam int CB_KBD_OFF_BIT = 4;
  localparam int CB_AUX_OFF_BIT = 5;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [7:0] cmd,
  output act_t       act
);

  always_comb begin
    act            = '0;
    act.rsp        = RSP_NONE;
    act.pend       = PEND_NONE;
    unique case (cmd)
      OP_RD_CMDB:  act.rsp  = RSP_CMDB;
      OP_WR_CMDB:  act.pend = PEND_CMDB;
      OP_AUX_OFF:  act.cb_set[CB_AUX_OFF_BIT] = 1'b1;
      OP_AUX_ON:   act.cb_clr[CB_AUX_OFF_BIT] = 1'b1;
      OP_SELFTEST: act.rsp  = RSP_SELF;
      OP_KBD_OFF:  act.cb_set[CB_KBD_OFF_BIT] = 1'b1;
      OP_KBD_ON:   act.cb_clr[CB_KBD_OFF_BIT] = 1'b1;
      OP_RD_OPORT: act.rsp  = RSP_OPORT;
      OP_WR_OPORT: act.pend = PEND_OPORT;
      OP_FAKE_KBD: act.pend = PEND_OBUF;
      OP_FAKE_AUX: act.pend = PEND_OBUF;
      OP_TO_AUX:   act.pend = PEND_AUX;
      OP_RD_LINES: act.rsp  = RSP_LINES;
      default: begin
        if (cmd[7:4] == 4'hF) begin
          act.pulse      = 1'b1;
          act.pulse_mask = ~cmd[3:0];
        end
      end
    endcase
  end

endmodule

// File: rtl/kbc_pulse_timer.sv
module kbc_pulse_timer #(
  parameter int PULSE_CYC = 300,
  parameter int NBITS     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NBITS-1:0] mask_in,
  output logic [NBITS-1:0] low_mask
);

  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0]    cnt_q;
  logic [NBITS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start) begin
      cnt_q  <= CW'(PULSE_CYC);
      mask_q <= mask_in;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign low_mask = (cnt_q != '0) ? mask_q : '0;

endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_pkg::*;
#(
  parameter int         PULSE_CYC = 300,
  parameter logic [7:0] CB_INIT   = 8'h00,
  parameter logic [7:0] OP_INIT   = 8'hC1,
  parameter logic [7:0] SELF_OK   = 8'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq,
  input  logic       dev_rx_valid,
  input  logic [7:0] dev_rx_data,
  input  logic       dev_rx_even,
  output logic       dev_rx_ready,
  output logic       kbd_tx_valid,
  output logic       aux_tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       tx_timeout,
  input  logic       rx_timeout,
  input  logic       kbd_unlocked,
  input  logic       kclk_in,
  input  logic       kdat_in,
  output logic [7:0] out_port
);

  localparam int PBITS = 4;

  logic       obf_q, obf_n;
  logic [7:0] obuf_q, obuf_n;
  logic       ibf_q, ibf_n;
  logic [7:0] ireg_q, ireg_n;
  logic       cd_q, cd_n;
  logic [7:0] cb_q, cb_n;
  logic [7:0] op_q, op_n;
  pend_e      pend_q, pend_n;
  logic       txv_q, txv_n;
  logic       txaux_q, txaux_n;
  logic [7:0] txd_q, txd_n;
  logic       par_q, par_n;
  logic       ttmo_q, ttmo_n;
  logic       rtmo_q, rtmo_n;
  logic       unl_q, kclk_q, kdat_q;
  logic       irq_q, irq_n;
  logic [7:0] rdata_q, rdata_n;

  act_t             act;
  logic             proc;
  logic             take_dev;
  logic             rd_data;
  logic             pulse_go;
  logic [PBITS-1:0] low_mask;
  logic [7:0]       op_view;
  logic [7:0]       stat;

  kbc_cmd_decode u_dec (
    .cmd (ireg_q),
    .act (act)
  );

  kbc_pulse_timer #(
    .PULSE_CYC (PULSE_CYC),
    .NBITS     (PBITS)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .start    (pulse_go),
    .mask_in  (act.pulse_mask),
    .low_mask (low_mask)
  );

  assign proc     = ibf_q & ~txv_q;
  assign pulse_go = proc & cd_q & act.pulse;
  assign take_dev = dev_rx_valid & dev_rx_ready;
  assign rd_data  = host_rd & ~host_sel;

  assign op_view = {op_q[7:6], ~ibf_q, obf_q, op_q[3:2], op_q[1:0]}
                   & ~{{(8-PBITS){1'b0}}, low_mask};
  assign stat    = {par_q, rtmo_q, ttmo_q, unl_q, cd_q, cb_q[2], ibf_q, obf_q};

  always_comb begin
    obf_n   = obf_q;
    obuf_n  = obuf_q;
    ibf_n   = ibf_q;
    ireg_n  = ireg_q;
    cd_n    = cd_q;
    cb_n    = cb_q;
    op_n    = op_q;
    pend_n  = pend_q;
    txv_n   = txv_q;
    txaux_n = txaux_q;
    txd_n   = txd_q;
    par_n   = par_q;
    rdata_n = rdata_q;

    if (host_rd) rdata_n = host_sel ? stat : obuf_q;
    if (rd_data) obf_n = 1'b0;
    ttmo_n = (ttmo_q & ~rd_data) | tx_timeout;
    rtmo_n = (rtmo_q & ~rd_data) | rx_timeout;

    // outgoing handshake completes
    if (txv_q && tx_ready) begin
      txv_n = 1'b0;
      ibf_n = 1'b0;
    end

    if (proc) begin
      ibf_n = 1'b0;
      if (cd_q) begin
        pend_n = act.pend;
        cb_n   = (cb_q & ~act.cb_clr) | act.cb_set;
        if (act.rsp != RSP_NONE) begin
          obf_n = 1'b1;
          par_n = 1'b0;
          case (act.rsp)
            RSP_CMDB:  obuf_n = cb_q;
            RSP_OPORT: obuf_n = op_view;
            RSP_LINES: obuf_n = {6'b0, kdat_q, kclk_q};
            RSP_SELF:  obuf_n = SELF_OK;
            default:   obuf_n = obuf_q;
          endcase
        end
      end else begin
        pend_n = PEND_NONE;
        case (pend_q)
          PEND_CMDB:  cb_n = ireg_q;
          PEND_OPORT: op_n = ireg_q;
          PEND_OBUF: begin
            obuf_n = ireg_q;
            obf_n  = 1'b1;
            par_n  = 1'b0;
          end
          PEND_AUX: begin
            txv_n   = 1'b1;
            txaux_n = 1'b1;
            txd_n   = ireg_q;
            ibf_n   = 1'b1;
          end
          default: begin
            txv_n   = 1'b1;
            txaux_n = 1'b0;
            txd_n   = ireg_q;
            ibf_n   = 1'b1;
          end
        endcase
      end
    end

    if (host_wr && !ibf_q) begin
      ibf_n  = 1'b1;
      ireg_n = host_wdata;
      cd_n   = host_sel;
    end

    if (take_dev) begin
      obuf_n = dev_rx_data;
      obf_n  = 1'b1;
      par_n  = dev_rx_even;
    end

    irq_n = obf_n & cb_n[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obf_q   <= 1'b0;
      obuf_q  <= '0;
      ibf_q   <= 1'b0;
      ireg_q  <= '0;
      cd_q    <= 1'b0;
      cb_q    <= CB_INIT;
      op_q    <= OP_INIT;
      pend_q  <= PEND_NONE;
      txv_q   <= 1'b0;
      txaux_q <= 1'b0;
      txd_q   <= '0;
      par_q   <= 1'b0;
      ttmo_q  <= 1'b0;
      rtmo_q  <= 1'b0;
      unl_q   <= 1'b0;
      kclk_q  <= 1'b0;
      kdat_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      obf_q   <= obf_n;
      obuf_q  <= obuf_n;
      ibf_q   <= ibf_n;
      ireg_q  <= ireg_n;
      cd_q    <= cd_n;
      cb_q    <= cb_n;
      op_q    <= op_n;
      pend_q  <= pend_n;
      txv_q   <= txv_n;
      txaux_q <= txaux_n;
      txd_q   <= txd_n;
      par_q   <= par_n;
      ttmo_q  <= ttmo_n;
      rtmo_q  <= rtmo_n;
      unl_q   <= kbd_unlocked;
      kclk_q  <= kclk_in;
      kdat_q  <= kdat_in;
      irq_q   <= irq_n;
      rdata_q <= rdata_n;
    end
  end

  assign host_rdata   = rdata_q;
  assign irq          = irq_q;
  assign dev_rx_ready = ~obf_q & ~ibf_q;
  assign kbd_tx_valid = txv_q & ~txaux_q;
  assign aux_tx_valid = txv_q & txaux_q;
  assign tx_data      = txd_q;
  assign out_port     = op_view;

endmodule

// File: rtl/kbc_host_regs_chk.sv
module kbc_host_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_sel,
  input logic       dev_rx_valid,
  input logic       tx_ready,
  input logic       irq,
  input logic       kbd_tx_valid,
  input logic       aux_tx_valid,
  input logic [7:0] tx_data,
  input logic       obf,
  input logic       ibf,
  input logic       cd,
  input logic [7:0] obuf
);

  a_r3_cmd_sets_cd: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel && !ibf) |=> (cd && ibf));

  a_r3_data_clears_cd: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_sel && !ibf) |=> (!cd && ibf));

  a_r4_tx_held: assert property (@(posedge clk) disable iff (rst)
    (kbd_tx_valid && !tx_ready) |=> (kbd_tx_valid && $stable(tx_data)));

  a_r7_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({kbd_tx_valid, aux_tx_valid}));

  a_r10_irq_needs_full: assert property (@(posedge clk) disable iff (rst)
    irq |-> obf);

  a_r11_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    (dev_rx_valid && obf && !ibf) |=> $stable(obuf));

  a_r13_read_empties: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_sel && obf && !ibf) |=> !obf);

endmodule

bind kbc_host_regs kbc_host_regs_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .host_sel     (host_sel),
  .dev_rx_valid (dev_rx_valid),
  .tx_ready     (tx_ready),
  .irq          (irq),
  .kbd_tx_valid (kbd_tx_valid),
  .aux_tx_valid (aux_tx_valid),
  .tx_data      (tx_data),
  .obf          (obf_q),
  .ibf          (ibf_q),
  .cd           (cd_q),
  .obuf         (obuf_q)
);

// File: tb/kbc_host_regs_tb.sv
`timescale 1ns/1ps
module kbc_host_regs_tb;

  localparam int P = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic irq;
  logic dev_rx_valid = 0, dev_rx_even = 0;
  logic [7:0] dev_rx_data = 0;
  logic dev_rx_ready, kbd_tx_valid, aux_tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1;
  logic tx_timeout = 0, rx_timeout = 0;
  logic kbd_unlocked = 1, kclk_in = 1, kdat_in = 0;
  logic [7:0] out_port;

  int total = 0;
  int bad = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  kbc_host_regs #(.PULSE_CYC(P)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_rx_even(dev_rx_even), .dev_rx_ready(dev_rx_ready),
    .kbd_tx_valid(kbd_tx_valid), .aux_tx_valid(aux_tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .tx_timeout(tx_timeout),
    .rx_timeout(rx_timeout), .kbd_unlocked(kbd_unlocked),
    .kclk_in(kclk_in), .kdat_in(kdat_in), .out_port(out_port)
  );

  // ---------------- behavioural reference model ----------------
  logic m_obf, m_ibf, m_cd, m_txv, m_txaux, m_par, m_tt, m_rt, m_unl, m_kc, m_kd, m_irq;
  logic [7:0] m_obuf, m_ireg, m_cb, m_op, m_txd, m_rdata;
  logic [3:0] m_pmask;
  int m_pend, m_pcnt;

  function automatic logic [7:0] m_view(logic [7:0] op, logic ibf, logic obf,
                                        int pcnt, logic [3:0] pm);
    logic [7:0] x;
    x = {op[7:6], ~ibf, obf, op[3:2], op[1:0]};
    if (pcnt > 0) x[3:0] = x[3:0] & ~pm;
    return x;
  endfunction

  always @(posedge clk) begin
    logic s_obf, s_ibf, s_cd, s_txv, s_par, s_tt, s_rt, s_unl, s_kc, s_kd, ready, rdd;
    logic [7:0] s_obuf, s_ireg, s_cb, s_op, rsp;
    int s_pend, s_pcnt;
    logic [3:0] s_pm;
    logic has_rsp;
    if (rst) begin
      m_obf = 0; m_ibf = 0; m_cd = 0; m_txv = 0; m_txaux = 0; m_par = 0;
      m_tt = 0; m_rt = 0; m_unl = 0; m_kc = 0; m_kd = 0; m_irq = 0;
      m_obuf = 0; m_ireg = 0; m_cb = 8'h00; m_op = 8'hC1; m_txd = 0; m_rdata = 0;
      m_pmask = 0; m_pend = 0; m_pcnt = 0;
    end else begin
      s_obf = m_obf; s_ibf = m_ibf; s_cd = m_cd; s_txv = m_txv; s_par = m_par;
      s_tt = m_tt; s_rt = m_rt; s_unl = m_unl; s_kc = m_kc; s_kd = m_kd;
      s_obuf = m_obuf; s_ireg = m_ireg; s_cb = m_cb; s_op = m_op;
      s_pend = m_pend; s_pcnt = m_pcnt; s_pm = m_pmask;
      ready = !s_obf && !s_ibf;
      rdd = host_rd && !host_sel;
      if (host_rd)
        m_rdata = host_sel ? {s_par, s_rt, s_tt, s_unl, s_cd, s_cb[2], s_ibf, s_obf} : s_obuf;
      if (rdd) m_obf = 0;
      m_tt = (s_tt && !rdd) || tx_timeout;
      m_rt = (s_rt && !rdd) || rx_timeout;
      if (s_pcnt > 0) m_pcnt = s_pcnt - 1;
      if (s_txv && tx_ready) begin m_txv = 0; m_ibf = 0; end
      if (s_ibf && !s_txv) begin
        m_ibf = 0;
        if (s_cd) begin
          m_pend = 0; has_rsp = 0; rsp = 0;
          case (s_ireg)
            8'h20: begin has_rsp = 1; rsp = s_cb; end
            8'h60: m_pend = 1;
            8'hA7: m_cb = s_cb | 8'h20;
            8'hA8: m_cb = s_cb & 8'hDF;
            8'hAA: begin has_rsp = 1; rsp = 8'h55; end
            8'hAD: m_cb = s_cb | 8'h10;
            8'hAE: m_cb = s_cb & 8'hEF;
            8'hD0: begin has_rsp = 1; rsp = m_view(s_op, s_ibf, s_obf, s_pcnt, s_pm); end
            8'hD1: m_pend = 2;
            8'hD2, 8'hD3: m_pend = 3;
            8'hD4: m_pend = 4;
            8'hE0: begin has_rsp = 1; rsp = {6'b0, s_kd, s_kc}; end
            default: if (s_ireg[7:4] == 4'hF) begin m_pcnt = P; m_pmask = ~s_ireg[3:0]; end
          endcase
          if (has_rsp) begin m_obuf = rsp; m_obf = 1; m_par = 0; end
        end else begin
          m_pend = 0;
          case (s_pend)
            1: m_cb = s_ireg;
            2: m_op = s_ireg;
            3: begin m_obuf = s_ireg; m_obf = 1; m_par = 0; end
            4: begin m_txv = 1; m_txaux = 1; m_txd = s_ireg; m_ibf = 1; end
            default: begin m_txv = 1; m_txaux = 0; m_txd = s_ireg; m_ibf = 1; end
          endcase
        end
      end
      if (host_wr && !s_ibf) begin m_ibf = 1; m_ireg = host_wdata; m_cd = host_sel; end
      if (dev_rx_valid && ready) begin m_obuf = dev_rx_data; m_obf = 1; m_par = dev_rx_even; end
      m_unl = kbd_unlocked; m_kc = kclk_in; m_kd = kdat_in;
      m_irq = m_obf && m_cb[0];
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 out_port", out_port, m_view(m_op, m_ibf, m_obf, m_pcnt, m_pmask));
      chk("R10 irq", {7'b0, irq}, {7'b0, m_irq});
      chk("R11 ready", {7'b0, dev_rx_ready}, {7'b0, !m_obf && !m_ibf});
      chk("R4 kbd_tx_valid", {7'b0, kbd_tx_valid}, {7'b0, m_txv && !m_txaux});
      chk("R7 aux_tx_valid", {7'b0, aux_tx_valid}, {7'b0, m_txv && m_txaux});
      if (m_txv) chk("R4 tx_data", tx_data, m_txd);
      chk("R2 host_rdata", host_rdata, m_rdata);
    end
  end

  task automatic hwrite(input logic sel, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_wr = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic hread(input logic sel, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_sel = sel;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic dev_send(input logic [7:0] d, input logic even);
    logic r;
    @(negedge clk); dev_rx_valid = 1; dev_rx_data = d; dev_rx_even = even;
    forever begin
      r = dev_rx_ready;
      @(negedge clk);
      if (r) break;
    end
    dev_rx_valid = 0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lows;
    logic a20_moved;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 out_port", out_port, 8'hE1);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    hread(1, v); chk("R1 R2 status", v, 8'h10);

    // R3 / R9 command byte bits
    hwrite(1, 8'hAD);
    hread(1, v); chk("R3 status after cmd", v, 8'h18);
    hwrite(1, 8'h20); hread(0, v); chk("R9 kbd off bit", v, 8'h10);
    hwrite(1, 8'hAE); hwrite(1, 8'h20); hread(0, v); chk("R9 kbd on", v, 8'h00);
    hwrite(1, 8'hA7); hwrite(1, 8'h20); hread(0, v); chk("R9 aux off bit", v, 8'h20);
    hwrite(1, 8'hA8); hwrite(1, 8'h20); hread(0, v); chk("R9 aux on", v, 8'h00);

    // R5 command byte write, system flag
    hwrite(1, 8'h60); hwrite(0, 8'h05);
    hread(1, v); chk("R5 R3 status sys flag, data clears bit3", v, 8'h14);
    chk("R10 irq idle", {7'b0, irq}, 8'h00);
    hwrite(1, 8'h20);
    chk("R10 irq on full", {7'b0, irq}, 8'h01);
    hread(0, v); chk("R5 read cmd byte", v, 8'h05);
    chk("R10 irq drops on read", {7'b0, irq}, 8'h00);

    // R8 self test and line states
    hwrite(1, 8'hAA); hread(0, v); chk("R8 self test", v, 8'h55);
    hwrite(1, 8'hE0); hread(0, v); chk("R8 lines", v, 8'h01);

    // R6 output port
    hwrite(1, 8'hD1); hwrite(0, 8'hC3);
    chk("R6 out_port loaded", out_port, 8'hE3);
    hwrite(1, 8'hD0); hread(0, v); chk("R6 read out port", v, 8'hC3);

    // R7 redirections
    hwrite(1, 8'hD2); hwrite(0, 8'h9A); hread(0, v); chk("R7 fake kbd byte", v, 8'h9A);
    hwrite(1, 8'hD3); hwrite(0, 8'h3C); hread(0, v); chk("R7 fake aux byte", v, 8'h3C);
    tx_ready = 0;
    hwrite(1, 8'hD4); hwrite(0, 8'h77);
    chk("R7 aux valid", {7'b0, aux_tx_valid}, 8'h01);
    chk("R7 aux data", tx_data, 8'h77);
    chk("R7 kbd idle", {7'b0, kbd_tx_valid}, 8'h00);
    @(negedge clk); tx_ready = 1; repeat (2) @(negedge clk);

    // R4 plain data to keyboard, held
    tx_ready = 0;
    hwrite(0, 8'h11);
    hread(1, v); chk("R4 input full while sending", v, 8'h16);
    repeat (5) @(negedge clk);
    chk("R4 kbd held", {7'b0, kbd_tx_valid}, 8'h01);
    chk("R4 kbd data", tx_data, 8'h11);
    tx_ready = 1; repeat (2) @(negedge clk);
    chk("R4 released", {7'b0, kbd_tx_valid}, 8'h00);

    // R11 device bytes
    dev_send(8'h1C, 1'b1);
    @(negedge clk);
    hread(1, v); chk("R11 R2 parity and full", v, 8'h95);
    @(negedge clk); dev_rx_valid = 1; dev_rx_data = 8'h2D; dev_rx_even = 0;
    repeat (4) @(negedge clk);
    chk("R11 held off", {7'b0, dev_rx_ready}, 8'h00);
    hread(0, v); chk("R11 no overwrite", v, 8'h1C);
    repeat (3) @(negedge clk); dev_rx_valid = 0;
    hread(0, v); chk("R11 later byte", v, 8'h2D);

    // R13 sticky timeouts
    @(negedge clk); tx_timeout = 1; rx_timeout = 1;
    @(negedge clk); tx_timeout = 0; rx_timeout = 0;
    @(negedge clk);
    hread(1, v); chk("R13 timeouts set", v, 8'h74);
    hread(0, v);
    hread(1, v); chk("R13 cleared by data read", v, 8'h14);

    // R12 pulse of bit 0 only
    hwrite(1, 8'hFE);
    lows = 0; a20_moved = 0;
    repeat (P + 20) begin
      @(negedge clk);
      if (!out_port[0]) lows++;
      if (!out_port[1]) a20_moved = 1;
    end
    chk("R12 pulse length", 8'(lows), 8'(P - 3));
    chk("R12 other bit untouched", {7'b0, a20_moved}, 8'h00);
    chk("R12 restored", out_port, 8'hE3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule